// File: doc/BRIEF.md
# MAC Warm-Reset Sequencer

This block takes one direction of an Ethernet MAC, receive or transmit, through a warm reset without software involvement. It works with two MAC flavours: a ten-gigabit style MAC and a one-gigabit style MAC. The two flavours differ in register layout, status field positions, reset bit count and wait times. A single start pulse selects the flavour and the direction. The sequencer then drives the MAC's register space through a one-transaction-at-a-time read/write master port.

The work runs in a fixed order, and the reset phase never begins before the stop phase has finished:

1. The sequencer reads the direction's config word and keeps a copy.
2. It writes the word back with only that direction's enable bit cleared.
3. It waits a graceful-stop interval, then polls the state-machine status until the direction's field reads idle.
4. It writes the self-clearing software-reset bits and polls until they read back clear.
5. It writes the saved config word back.

A one-cycle `done` pulse ends every run. A `timeout` flag reports a poll that never reached its goal.

The register port is valid/ready. A request (`bus_addr`, `bus_we`, `bus_wdata`) is offered with `bus_valid` and must stay unchanged until the cycle in which `bus_ready` is high. The slave may hold `bus_ready` low for as long as it likes. A write is complete at acceptance. A read is complete when `bus_rvalid` returns with `bus_rdata`. No new request is offered until the current one has completed. There is no back-pressure on read data: the sequencer always takes `bus_rvalid` in the cycle it appears.

Top module: `mac_wreset_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout` and `bus_valid` are all low, and no request is offered while `busy` is low.
- R2: An offered request holds its address, write flag and write data until accepted. A read is not followed by another request before its `bus_rvalid` has returned.
- R3: In idle, a `start` pulse latches `start_kind` (0 = ten-gigabit style, 1 = one-gigabit style) and `start_dir` (0 = receive, 1 = transmit), and raises `busy` in the next cycle. A `start` seen while `busy` is high is ignored and does not change the ongoing run.
- R4: A run begins with a read of the config register, followed by a write of the same word with only the enable bit cleared:
  - ten-gigabit style: one shared config register; bit 0 for transmit, bit 8 for receive;
  - one-gigabit style: a separate config register per direction; bit 0.
- R5: Before the first status poll, at least the graceful-stop wait elapses after the disabling write, plus one poll interval. The stop wait is `TEN_STOP_WAIT` or `ONE_STOP_WAIT`. Polls are spaced at least one interval apart: `ONE_STOP_GAP` for one-gigabit style stop polls, and `POLL_GAP` for all others.
- R6: The stop phase ends on a status read with the direction's field at zero:
  - ten-gigabit style: transmit bits 2:0, receive bit 7;
  - one-gigabit style: transmit bits 19:16, receive bits 26:23.
  Bits outside the field are ignored.
- R7: After the stop phase, the direction's reset register is written with 0x3 (ten-gigabit style) or 0x1 (one-gigabit style).
- R8: The reset phase ends only when the written bits read back zero: both bit 0 and bit 1 for ten-gigabit style, bit 0 alone for one-gigabit style. Reset reads are spaced `POLL_GAP` apart.
- R9: A successful run ends by writing the saved config word back unchanged. In the cycle that write completes, the sequencer issues a one-cycle `done` pulse and drops `busy`.
- R10: Each phase counts non-idle poll reads from zero. When a non-idle read arrives with the count already equal to `poll_limit`, the run stops:
  - no further requests are issued, so a limit of L allows at most L+1 reads per phase;
  - `done` pulses;
  - `timeout` rises in the same cycle and stays high until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, honoured only when idle |
| start_kind | input | 1 | MAC flavour: 0 ten-gigabit style, 1 one-gigabit style |
| start_dir | input | 1 | Direction: 0 receive, 1 transmit |
| poll_limit | input | LIMW | Non-idle poll reads tolerated per phase |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| timeout | output | 1 | Last run gave up on a poll; held until next start |
| bus_valid | output | 1 | Register request offered |
| bus_ready | input | 1 | Slave accepts the offered request |
| bus_addr | output | AW | Register offset of the request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_wdata | output | 32 | Write data |
| bus_rvalid | input | 1 | Read data returned |
| bus_rdata | input | 32 | Read data |

## Verification
Most faults in the sequencer's state show up on the register port within one transaction:

- a wrong kind or direction latch gives a wrong address or bit mask on the first config write;
- a wrong status or reset field test ends or extends polling, which shows as a missing or extra read before the reset write or before the restore;
- a stale saved word shows in the last write of the run;
- a timer fault shows as two accepted requests closer together than the programmed interval.

Poll counter faults show at the end of the run. The count of reads in a timed-out phase, and the `timeout` level at the `done` pulse, expose an off-by-one in the limit compare.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {KIND_TEN = 1'b0, KIND_ONE = 1'b1} mac_kind_e;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} mac_dir_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_CFG_RD, SQ_CFG_WR, SQ_STOP_WAIT, SQ_STAT_GAP,
    SQ_STAT_RD, SQ_RST_WR, SQ_RST_GAP, SQ_RST_RD, SQ_RESTORE
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Enable bit of the selected direction inside its config word.
  function automatic word_t enable_mask(input mac_kind_e k, input mac_dir_e d);
    if (k == KIND_TEN && d == DIR_RX) return word_t'(1) << 8;
    return word_t'(1);
  endfunction

  // True while the direction's state-machine field is not idle.
  function automatic logic stop_busy(input mac_kind_e k, input mac_dir_e d, input word_t s);
    if (k == KIND_TEN) return (d == DIR_TX) ? (|s[2:0]) : s[7];
    return (d == DIR_TX) ? (|s[19:16]) : (|s[26:23]);
  endfunction

  // Self-clearing software-reset bits to set.
  function automatic word_t reset_cmd(input mac_kind_e k);
    return (k == KIND_TEN) ? word_t'(3) : word_t'(1);
  endfunction

  function automatic logic reset_pending(input mac_kind_e k, input word_t s);
    return |(s & reset_cmd(k));
  endfunction

endpackage

// File: rtl/mwr_reg_master.sv
module mwr_reg_master
  import mwr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  word_t         req_wdata,
  output logic          xfer_done,
  output word_t         xfer_rdata,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output word_t         bus_wdata,
  input  logic          bus_rvalid,
  input  word_t         bus_rdata
);

  typedef enum logic [1:0] {M_IDLE, M_ADDR, M_DATA} mst_state_e;
  mst_state_e mst_q;

  logic [AW-1:0] addr_q;
  logic          we_q;
  word_t         wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q   <= M_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      unique case (mst_q)
        M_IDLE: if (req) begin
          addr_q  <= req_addr;
          we_q    <= req_we;
          wdata_q <= req_wdata;
          mst_q   <= M_ADDR;
        end
        M_ADDR: if (bus_ready) mst_q <= we_q ? M_IDLE : M_DATA;
        M_DATA: if (bus_rvalid) mst_q <= M_IDLE;
        default: mst_q <= M_IDLE;
      endcase
    end
  end

  assign bus_valid  = (mst_q == M_ADDR);
  assign bus_addr   = addr_q;
  assign bus_we     = we_q;
  assign bus_wdata  = wdata_q;
  assign xfer_done  = ((mst_q == M_ADDR) && bus_ready && we_q) ||
                      ((mst_q == M_DATA) && bus_rvalid);
  assign xfer_rdata = bus_rdata;

endmodule

// File: rtl/mwr_gap_timer.sv
module mwr_gap_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run_q && (cnt_q == '0);

endmodule

// File: rtl/mwr_poll_counter.sv
module mwr_poll_counter #(
  parameter int LIMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            bump,
  input  logic [LIMW-1:0] limit,
  output logic            over
);

  logic [LIMW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clear)              cnt_q <= '0;
    else if (bump && !(&cnt_q))  cnt_q <= cnt_q + 1'b1;
  end

  // The next non-idle read would push the count past the limit.
  assign over = (cnt_q >= limit);

endmodule

// File: rtl/mac_wreset_seq.sv
module mac_wreset_seq
  import mwr_pkg::*;
#(
  parameter int AW            = 16,
  parameter int LIMW          = 8,
  parameter int TEN_STOP_WAIT = 3000,
  parameter int ONE_STOP_WAIT = 30000,
  parameter int POLL_GAP      = 100,
  parameter int ONE_STOP_GAP  = 1000,
  parameter logic [AW-1:0] TEN_CFG_OFS   = 16'h0010,
  parameter logic [AW-1:0] TEN_STAT_OFS  = 16'h0014,
  parameter logic [AW-1:0] TEN_TXRST_OFS = 16'h0000,
  parameter logic [AW-1:0] TEN_RXRST_OFS = 16'h0004,
  parameter logic [AW-1:0] ONE_TXCFG_OFS = 16'h0110,
  parameter logic [AW-1:0] ONE_RXCFG_OFS = 16'h0118,
  parameter logic [AW-1:0] ONE_STAT_OFS  = 16'h0120,
  parameter logic [AW-1:0] ONE_TXRST_OFS = 16'h0100,
  parameter logic [AW-1:0] ONE_RXRST_OFS = 16'h0104
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_kind,
  input  logic            start_dir,
  input  logic [LIMW-1:0] poll_limit,
  output logic            busy,
  output logic            done,
  output logic            timeout,
  output logic            bus_valid,
  input  logic            bus_ready,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_we,
  output logic [31:0]     bus_wdata,
  input  logic            bus_rvalid,
  input  logic [31:0]     bus_rdata
);

  localparam int LONGEST = max_of(max_of(TEN_STOP_WAIT, ONE_STOP_WAIT),
                                  max_of(POLL_GAP, ONE_STOP_GAP));
  localparam int TW = $clog2(LONGEST + 1);

  seq_state_e state_q, state_d;
  mac_kind_e  kind_q;
  mac_dir_e   dir_q;
  word_t      saved_q;
  logic       done_q, timeout_q;

  // Per-run register map, chosen from the latched kind and direction.
  logic [AW-1:0] cfg_addr, stat_addr, rst_addr;
  logic [TW-1:0] stop_wait, stop_gap, rst_gap;

  always_comb begin
    if (kind_q == KIND_TEN) begin
      cfg_addr  = TEN_CFG_OFS;
      stat_addr = TEN_STAT_OFS;
      rst_addr  = (dir_q == DIR_TX) ? TEN_TXRST_OFS : TEN_RXRST_OFS;
      stop_wait = TW'(TEN_STOP_WAIT);
      stop_gap  = TW'(POLL_GAP);
    end else begin
      cfg_addr  = (dir_q == DIR_TX) ? ONE_TXCFG_OFS : ONE_RXCFG_OFS;
      stat_addr = ONE_STAT_OFS;
      rst_addr  = (dir_q == DIR_TX) ? ONE_TXRST_OFS : ONE_RXRST_OFS;
      stop_wait = TW'(ONE_STOP_WAIT);
      stop_gap  = TW'(ONE_STOP_GAP);
    end
    rst_gap = TW'(POLL_GAP);
  end

  // Register master request for the current state.
  logic          req, req_we, xfer_done;
  logic [AW-1:0] req_addr;
  word_t         req_wdata, xfer_rdata;

  always_comb begin
    req       = 1'b0;
    req_we    = 1'b0;
    req_addr  = cfg_addr;
    req_wdata = '0;
    unique case (state_q)
      SQ_CFG_RD:  req = 1'b1;
      SQ_CFG_WR:  begin req = 1'b1; req_we = 1'b1; req_wdata = saved_q & ~enable_mask(kind_q, dir_q); end
      SQ_STAT_RD: begin req = 1'b1; req_addr = stat_addr; end
      SQ_RST_WR:  begin req = 1'b1; req_we = 1'b1; req_addr = rst_addr; req_wdata = reset_cmd(kind_q); end
      SQ_RST_RD:  begin req = 1'b1; req_addr = rst_addr; end
      SQ_RESTORE: begin req = 1'b1; req_we = 1'b1; req_wdata = saved_q; end
      default: ;
    endcase
  end

  mwr_reg_master #(.AW(AW)) u_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .xfer_done  (xfer_done),
    .xfer_rdata (xfer_rdata),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata)
  );

  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;

  mwr_gap_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  logic cnt_clear, cnt_bump, cnt_over;

  mwr_poll_counter #(.LIMW(LIMW)) u_polls (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cnt_clear),
    .bump  (cnt_bump),
    .limit (poll_limit),
    .over  (cnt_over)
  );

  // Sequencing.
  logic finish_ok, finish_to;

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = stop_gap;
    cnt_clear = 1'b0;
    cnt_bump  = 1'b0;
    finish_ok = 1'b0;
    finish_to = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (start) begin
        cnt_clear = 1'b1;
        state_d   = SQ_CFG_RD;
      end
      SQ_CFG_RD: if (xfer_done) state_d = SQ_CFG_WR;
      SQ_CFG_WR: if (xfer_done) begin
        tmr_load = 1'b1;
        tmr_val  = stop_wait;
        state_d  = SQ_STOP_WAIT;
      end
      SQ_STOP_WAIT: if (tmr_expired) begin
        tmr_load = 1'b1;
        state_d  = SQ_STAT_GAP;
      end
      SQ_STAT_GAP: if (tmr_expired) state_d = SQ_STAT_RD;
      SQ_STAT_RD: if (xfer_done) begin
        if (!stop_busy(kind_q, dir_q, xfer_rdata)) begin
          cnt_clear = 1'b1;
          state_d   = SQ_RST_WR;
        end else if (cnt_over) begin
          finish_to = 1'b1;
          state_d   = SQ_IDLE;
        end else begin
          cnt_bump = 1'b1;
          tmr_load = 1'b1;
          state_d  = SQ_STAT_GAP;
        end
      end
      SQ_RST_WR: if (xfer_done) begin
        tmr_load = 1'b1;
        tmr_val  = rst_gap;
        state_d  = SQ_RST_GAP;
      end
      SQ_RST_GAP: if (tmr_expired) state_d = SQ_RST_RD;
      SQ_RST_RD: if (xfer_done) begin
        if (!reset_pending(kind_q, xfer_rdata)) begin
          state_d = SQ_RESTORE;
        end else if (cnt_over) begin
          finish_to = 1'b1;
          state_d   = SQ_IDLE;
        end else begin
          cnt_bump = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = rst_gap;
          state_d  = SQ_RST_GAP;
        end
      end
      SQ_RESTORE: if (xfer_done) begin
        finish_ok = 1'b1;
        state_d   = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      kind_q    <= KIND_TEN;
      dir_q     <= DIR_RX;
      saved_q   <= '0;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_ok || finish_to;
      if (state_q == SQ_IDLE && start) begin
        kind_q    <= mac_kind_e'(start_kind);
        dir_q     <= mac_dir_e'(start_dir);
        timeout_q <= 1'b0;
      end else if (finish_to) begin
        timeout_q <= 1'b1;
      end
      if (state_q == SQ_CFG_RD && xfer_done) saved_q <= xfer_rdata;
    end
  end

  assign busy    = (state_q != SQ_IDLE);
  assign done    = done_q;
  assign timeout = timeout_q;

endmodule

// File: rtl/mwr_checker.sv
module mwr_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          timeout,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [31:0]   bus_wdata
);

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid);

  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  a_r3_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

  a_r10_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout && !(start && !busy) |=> timeout);

  a_r10_timeout_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> !timeout);

endmodule

bind mac_wreset_seq mwr_checker #(.AW(AW)) u_mwr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata)
);

// File: tb/mac_wreset_seq_bench.sv
module mac_wreset_seq_bench;
  import mwr_pkg::*;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 16;
  localparam int LIMW = 8;
  localparam int TSW = 40;
  localparam int OSW = 90;
  localparam int PG  = 6;
  localparam int OSG = 11;
  localparam logic [AW-1:0] A_TCFG = 16'h0010, A_TSTAT = 16'h0014, A_TTXR = 16'h0000, A_TRXR = 16'h0004;
  localparam logic [AW-1:0] A_OTXC = 16'h0110, A_ORXC = 16'h0118, A_OSTAT = 16'h0120, A_OTXR = 16'h0100, A_ORXR = 16'h0104;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, start_kind = 1'b0, start_dir = 1'b0;
  logic [LIMW-1:0] poll_limit = '0;
  logic busy, done, timeout, bus_valid, bus_we;
  logic bus_ready = 1'b0, bus_rvalid = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;

  always #2.5 clk = ~clk;

  mac_wreset_seq #(
    .AW(AW), .LIMW(LIMW), .TEN_STOP_WAIT(TSW), .ONE_STOP_WAIT(OSW), .POLL_GAP(PG), .ONE_STOP_GAP(OSG),
    .TEN_CFG_OFS(A_TCFG), .TEN_STAT_OFS(A_TSTAT), .TEN_TXRST_OFS(A_TTXR), .TEN_RXRST_OFS(A_TRXR),
    .ONE_TXCFG_OFS(A_OTXC), .ONE_RXCFG_OFS(A_ORXC), .ONE_STAT_OFS(A_OSTAT),
    .ONE_TXRST_OFS(A_OTXR), .ONE_RXRST_OFS(A_ORXR)
  ) u_mac_wreset_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_kind(start_kind), .start_dir(start_dir),
    .poll_limit(poll_limit), .busy(busy), .done(done), .timeout(timeout),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic          we;
    logic [AW-1:0] addr;
    word_t         data;
    int            min_gap;
    string         req;
  } exp_t;
  exp_t expq[$];

  task automatic push(input logic we, input logic [AW-1:0] a, input word_t d, input int g, input string r);
    exp_t e;
    e.we = we; e.addr = a; e.data = d; e.min_gap = g; e.req = r;
    expq.push_back(e);
  endtask

  // Slave model state.
  int stat_left = 0, rst_left = 0, pend = 0, last_acc = 0, done_seen = 0, rdy_phase = 0;
  logic cur_kind = 1'b0, cur_dir = 1'b0;
  word_t cfg_val = '0, pend_data = '0;

  function automatic logic [AW-1:0] cfg_a(input logic k, input logic d);
    return (k == 1'b0) ? A_TCFG : (d ? A_OTXC : A_ORXC);
  endfunction
  function automatic logic [AW-1:0] stat_a(input logic k);
    return (k == 1'b0) ? A_TSTAT : A_OSTAT;
  endfunction
  function automatic logic [AW-1:0] rst_a(input logic k, input logic d);
    if (k == 1'b0) return d ? A_TTXR : A_TRXR;
    return d ? A_OTXR : A_ORXR;
  endfunction
  // Busy words set only the field under test; idle words set neighbouring fields.
  function automatic word_t stat_word(input logic k, input logic d, input bit bsy);
    if (k == 1'b0 && d)  return bsy ? 32'h0000_0005 : 32'h0000_0080;
    if (k == 1'b0)       return bsy ? 32'h0000_0080 : 32'h0000_0007;
    if (d)               return bsy ? 32'h000A_0000 : 32'h0780_0000;
    return bsy ? 32'h0280_0000 : 32'h000F_0000;
  endfunction
  function automatic word_t rst_word(input logic k, input bit bsy);
    if (k == 1'b0) return bsy ? 32'h0000_0002 : 32'h0000_0004;
    return bsy ? 32'h0000_0001 : 32'h0000_0002;
  endfunction

  // Slave and scoreboard monitor, both acting away from the active edge.
  always @(negedge clk) begin
    bus_rvalid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        bus_rvalid = 1'b1;
        bus_rdata  = pend_data;
      end
    end
    bus_ready = ((rdy_phase % 3) != 2);
    rdy_phase++;
    if (rst_n && done) done_seen++;
    if (rst_n && bus_valid && bus_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R3", "unexpected request addr", longint'(bus_addr), 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(bus_we == e.we && bus_addr == e.addr, e.req, "request kind/address",
              longint'({bus_we, bus_addr}), longint'({e.we, e.addr}));
        if (e.we) check(bus_wdata == e.data, e.req, "write data", longint'(bus_wdata), longint'(e.data));
        if (e.min_gap > 0) check(cyc - last_acc >= e.min_gap, "R5", "spacing in cycles",
                                 longint'(cyc - last_acc), longint'(e.min_gap));
      end
      last_acc = cyc;
      if (!bus_we) begin
        pend = 2;
        if (bus_addr == stat_a(cur_kind)) begin
          pend_data = stat_word(cur_kind, cur_dir, stat_left > 0);
          if (stat_left > 0) stat_left--;
        end else if (bus_addr == rst_a(cur_kind, cur_dir)) begin
          pend_data = rst_word(cur_kind, rst_left > 0);
          if (rst_left > 0) rst_left--;
        end else if (bus_addr == cfg_a(cur_kind, cur_dir)) begin
          pend_data = cfg_val;
        end else begin
          pend_data = 32'hDEAD_BEEF;
        end
      end
    end
  end

  // Driver: queue the expected transactions, launch, and wait for the end.
  task automatic run_seq(input logic k, input logic d, input word_t cfg, input int ns, input int nr,
                         input int lim, input bit poke);
    bit exp_to = 1'b0;
    int base, n;
    word_t en = (k == 1'b0 && d == 1'b0) ? 32'h100 : 32'h1;
    int swait = k ? OSW : TSW;
    int sgap  = k ? OSG : PG;
    int nsr   = (ns <= lim) ? ns + 1 : lim + 1;
    int nrr   = (nr <= lim) ? nr + 1 : lim + 1;
    cur_kind = k; cur_dir = d; cfg_val = cfg; stat_left = ns; rst_left = nr;
    push(1'b0, cfg_a(k, d), '0, 0, "R4");
    push(1'b1, cfg_a(k, d), cfg & ~en, 0, "R4");
    for (int i = 0; i < nsr; i++) push(1'b0, stat_a(k), '0, (i == 0) ? swait + sgap : sgap, "R6");
    if (ns > lim) exp_to = 1'b1;
    else begin
      push(1'b1, rst_a(k, d), k ? 32'h1 : 32'h3, 0, "R7");
      for (int i = 0; i < nrr; i++) push(1'b0, rst_a(k, d), '0, PG, "R8");
      if (nr > lim) exp_to = 1'b1;
      else push(1'b1, cfg_a(k, d), cfg, 0, "R9");
    end
    base = done_seen;
    @(negedge clk);
    start = 1'b1; start_kind = k; start_dir = d; poll_limit = LIMW'(lim);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R3", "busy after start", busy, 1);
    check(timeout == 1'b0, "R10", "timeout cleared by start", timeout, 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1'b1; start_kind = ~k; start_dir = ~d;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R3", "busy kept when start ignored", busy, 1);
    end
    n = 0;
    while (done_seen == base && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done_seen == base + 1, "R9", "done pulse count", done_seen - base, 1);
    @(negedge clk);
    check(busy == 1'b0, "R9", "busy after done", busy, 0);
    check(timeout == exp_to, "R10", "timeout level", timeout, exp_to);
    check(expq.size() == 0, exp_to ? "R10" : "R9", "pending expected requests", expq.size(), 0);
    expq.delete();
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && timeout == 1'b0 && bus_valid == 1'b0,
          "R1", "outputs in reset", longint'({busy, done, timeout, bus_valid}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && bus_valid == 1'b0, "R1", "idle after reset", longint'({busy, bus_valid}), 0);
    // R4/R6 ten-gigabit transmit, R2 under back-pressure
    run_seq(1'b0, 1'b1, 32'h0000_0131, 2, 1, 4, 1'b0);
    // R8 ten-gigabit receive: only bit 1 pending must keep polling
    run_seq(1'b0, 1'b0, 32'h0000_0F01, 3, 2, 4, 1'b0);
    // R5 one-gigabit transmit, long stop wait
    run_seq(1'b1, 1'b1, 32'hFFFF_FFFF, 1, 1, 3, 1'b0);
    // R3 one-gigabit receive with an ignored start mid-run
    run_seq(1'b1, 1'b0, 32'h0000_0005, 0, 3, 5, 1'b1);
    // R10 stop-phase timeout: limit 2, five busy reads
    run_seq(1'b0, 1'b1, 32'h0000_0001, 5, 0, 2, 1'b0);
    repeat (20) @(negedge clk);
    check(timeout == 1'b1 && bus_valid == 1'b0, "R10", "timeout held, bus quiet",
          longint'({timeout, bus_valid}), 2);
    // R10 reset-phase timeout with limit 0
    run_seq(1'b1, 1'b0, 32'h0000_0011, 0, 2, 0, 1'b0);
    // R9 limit 0 with no busy reads completes normally
    run_seq(1'b0, 1'b0, 32'h0000_0100, 0, 0, 0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule